// File: doc/BRIEF.md
# Test-Bus Controller Host Register Port

This block is the slave port through which a host processor programs a scan-bus controller. The host presents a 5-bit register address and a 16-bit word and pulses active-low read or write strobes. The port decodes 24 register slots: configuration words, an interrupt flag word, a status word, two command slots, a read-buffer slot and a write-buffer slot. The rest of the controller runs on the test clock, and the host side needs no knowledge of that clock's period.

A write is latched by the rising edge of the write strobe. It is then carried into the test-clock domain by a toggle handed through a synchronizer chain. While a transfer is in flight, the active-low ready line stays high. The same happens after a read and throughout reset. Command and write-buffer writes, and reads of the read buffer, each raise a one-cycle pulse in the test-clock domain. Sticky interrupt flags, qualified by an enable mask, drive an active-low interrupt line until the host clears them.

Pulling the test-reset input low clears the port at once. When the input goes high again, a software reset phase runs for a fixed number of test-clock cycles before the port accepts traffic.

Top module: `tbc_host_port`

## Requirements
- R1: Addresses 0 to 17 are read/write configuration words. Each word is stored on a write, read back unchanged, and driven on `cfg_q` with word i at bits [16*i+15:16*i]. Bits [3:0] of word 0 are the interrupt enable mask.
- R2: A write takes the address and data present at the rising edge of `host_wr_n`. A change of `host_wdata` after that edge does not alter the stored value.
- R3: After a rising edge of `host_wr_n` or `host_rd_n`, `host_rdy_n` is high at once. It stays high through exactly 3 rising edges of `tck` and is low after the third.
- R4: A write to address 20 stores the word in `cmd_q[15:0]`, and a write to address 21 stores it in `cmd_q[31:16]`. The write raises `cmd_start[0]` or `cmd_start[1]` respectively for one `tck` cycle, in the cycle when ready returns low. Both slots read back.
- R5: A read of address 22 (binary 10110) returns `rbuf_in`. When that read's strobe ends, `rbuf_pop` is raised for one cycle. A read of any other address does not raise `rbuf_pop`.
- R6: `host_rd_oe` equals the inverse of `host_rd_n`. A read of address 19 returns `status_in`.
- R7: Writes to addresses 24 to 31 and to the read-only addresses 19 and 22 change no register and raise no pulse. Reads of addresses 24 to 31 return zero.
- R8: A high bit of `irq_in` at a `tck` edge sets the matching sticky flag, which reads back in bits [3:0] of address 18. A write to address 18 clears the flags whose data bit is 1, and a set in the same cycle wins. `host_int_n` is low exactly when some flag is set and also enabled in word 0.
- R9: While `trst_n` is low, `host_rdy_n` and `core_rst` are high and all registers are zero. After `trst_n` rises, both stay high through 8 rising edges of `tck` and are low after the eighth.
- R10: A write to address 23 stores the word on `wbuf_q`, raises `wbuf_load` for one cycle, and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset |
| host_addr | input | 5 | Register address |
| host_wdata | input | 16 | Write data from host |
| host_rd_n | input | 1 | Active-low read strobe |
| host_wr_n | input | 1 | Active-low write strobe |
| host_rdata | output | 16 | Read data to host |
| host_rd_oe | output | 1 | Drive enable for the host data bus |
| host_rdy_n | output | 1 | Active-low ready |
| host_int_n | output | 1 | Active-low interrupt |
| status_in | input | 16 | Status word from the controller core |
| rbuf_in | input | 16 | Read-buffer word from the serial path |
| irq_in | input | 4 | Interrupt event sources |
| cfg_q | output | 288 | Configuration words, flattened |
| cmd_q | output | 32 | Two command words, flattened |
| cmd_start | output | 2 | One-cycle command start pulses |
| wbuf_q | output | 16 | Write-buffer word |
| wbuf_load | output | 1 | One-cycle write-buffer load pulse |
| rbuf_pop | output | 1 | One-cycle read-buffer consumed pulse |
| core_rst | output | 1 | Reset for the rest of the controller |

## Verification
A synchronizer chain that drops or doubles a toggle shows at the ports within a few test-clock cycles. Ready then either never returns low or returns after the wrong number of edges, and a command or buffer pulse either goes missing or repeats. A wrong decode shows on the next read of the slot concerned, or on `cfg_q` right after the write completes. A wrong flag or mask state shows on `host_int_n` one edge after the triggering event. A miscounting reset sequencer shows as ready going low early or late after `trst_n` rises.

// File: rtl/hostif_pkg.sv
package hostif_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int N_CFG  = 18;
    localparam int N_CMD  = 2;
    localparam int N_IRQ  = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam addr_t A_FLAGS  = addr_t'(N_CFG);
    localparam addr_t A_STATUS = A_FLAGS + addr_t'(1);
    localparam addr_t A_CMD0   = A_STATUS + addr_t'(1);
    localparam addr_t A_RBUF   = 5'b10110;
    localparam addr_t A_WBUF   = A_RBUF + addr_t'(1);

    typedef enum logic [2:0] {
        K_CFG, K_FLAGS, K_STATUS, K_CMD, K_RBUF, K_WBUF, K_NONE
    } kind_e;

    typedef struct packed {
        addr_t addr;
        word_t data;
    } xfer_t;

    function automatic kind_e slot_kind(addr_t a);
        if (a < addr_t'(N_CFG))                          return K_CFG;
        if (a == A_FLAGS)                                return K_FLAGS;
        if (a == A_STATUS)                               return K_STATUS;
        if (a >= A_CMD0 && a < A_CMD0 + addr_t'(N_CMD))  return K_CMD;
        if (a == A_RBUF)                                 return K_RBUF;
        if (a == A_WBUF)                                 return K_WBUF;
        return K_NONE;
    endfunction

endpackage

// File: rtl/hif_strobe_capture.sv
module hif_strobe_capture
    import hostif_pkg::*;
(
    input  logic  hw_rst,
    input  logic  wr_n,
    input  logic  rd_n,
    input  addr_t addr,
    input  word_t wdata,
    output xfer_t wr_q,
    output logic  wr_tog,
    output addr_t rd_addr_q,
    output logic  rd_tog
);

    // The strobes are the only clocks here, so reset must be asynchronous.
    always_ff @(posedge wr_n or posedge hw_rst) begin
        if (hw_rst) begin
            wr_q   <= '0;
            wr_tog <= 1'b0;
        end else begin
            wr_q   <= '{addr: addr, data: wdata};
            wr_tog <= ~wr_tog;
        end
    end

    always_ff @(posedge rd_n or posedge hw_rst) begin
        if (hw_rst) begin
            rd_addr_q <= '0;
            rd_tog    <= 1'b0;
        end else begin
            rd_addr_q <= addr;
            rd_tog    <= ~rd_tog;
        end
    end

endmodule

// File: rtl/hif_toggle_sync.sv
module hif_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tog,
    output logic pulse,
    output logic seen
);

    logic [STAGES-1:0] chain;
    logic              seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            seen_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], tog};
            seen_q <= chain[STAGES-1];
        end
    end

    assign pulse = chain[STAGES-1] ^ seen_q;
    assign seen  = seen_q;

endmodule

// File: rtl/hif_reset_seq.sv
module hif_reset_seq #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic trst_n,
    output logic hw_rst,
    output logic core_rst
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!trst_n)
            remain <= CW'(CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign hw_rst   = !trst_n;
    assign core_rst = !trst_n || (remain != '0);

endmodule

// File: rtl/hif_regfile.sv
module hif_regfile
    import hostif_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_pulse,
    input  xfer_t                   wr_q,
    input  logic                    rd_pulse,
    input  addr_t                   rd_addr_q,
    input  addr_t                   host_addr,
    input  word_t                   status_in,
    input  word_t                   rbuf_in,
    input  logic [N_IRQ-1:0]        irq_in,
    output logic [N_CFG*DATA_W-1:0] cfg_q,
    output logic [N_CMD*DATA_W-1:0] cmd_q,
    output logic [N_CMD-1:0]        cmd_start,
    output word_t                   wbuf_q,
    output logic                    wbuf_load,
    output logic                    rbuf_pop,
    output word_t                   rdata,
    output logic                    int_n
);

    word_t            cfg [N_CFG];
    word_t            cmd [N_CMD];
    logic [N_IRQ-1:0] flags;
    logic [N_IRQ-1:0] clr;

    for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg[i] <= '0;
            else if (wr_pulse && wr_q.addr == addr_t'(i))
                cfg[i] <= wr_q.data;
        end
        assign cfg_q[i*DATA_W +: DATA_W] = cfg[i];
    end

    for (genvar i = 0; i < N_CMD; i++) begin : g_cmd
        logic hit;
        assign hit = wr_pulse && wr_q.addr == A_CMD0 + addr_t'(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                cmd[i]       <= '0;
                cmd_start[i] <= 1'b0;
            end else begin
                cmd_start[i] <= hit;
                if (hit)
                    cmd[i] <= wr_q.data;
            end
        end
        assign cmd_q[i*DATA_W +: DATA_W] = cmd[i];
    end

    assign clr = (wr_pulse && wr_q.addr == A_FLAGS) ? wr_q.data[N_IRQ-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags     <= '0;
            wbuf_q    <= '0;
            wbuf_load <= 1'b0;
            rbuf_pop  <= 1'b0;
        end else begin
            flags     <= (flags & ~clr) | irq_in;
            wbuf_load <= wr_pulse && wr_q.addr == A_WBUF;
            rbuf_pop  <= rd_pulse && rd_addr_q == A_RBUF;
            if (wr_pulse && wr_q.addr == A_WBUF)
                wbuf_q <= wr_q.data;
        end
    end

    assign int_n = ~|(flags & cfg[0][N_IRQ-1:0]);

    always_comb begin
        rdata = '0;
        unique case (slot_kind(host_addr))
            K_CFG:    rdata = cfg[host_addr];
            K_FLAGS:  rdata = word_t'(flags);
            K_STATUS: rdata = status_in;
            K_CMD: begin
                for (int i = 0; i < N_CMD; i++)
                    if (host_addr == A_CMD0 + addr_t'(i))
                        rdata = cmd[i];
            end
            K_RBUF:   rdata = rbuf_in;
            K_WBUF:   rdata = wbuf_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/tbc_host_port.sv
module tbc_host_port
    import hostif_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int SWRST_CYCLES = 8
) (
    input  logic                    tck,
    input  logic                    trst_n,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic [DATA_W-1:0]       host_wdata,
    input  logic                    host_rd_n,
    input  logic                    host_wr_n,
    output logic [DATA_W-1:0]       host_rdata,
    output logic                    host_rd_oe,
    output logic                    host_rdy_n,
    output logic                    host_int_n,
    input  logic [DATA_W-1:0]       status_in,
    input  logic [DATA_W-1:0]       rbuf_in,
    input  logic [N_IRQ-1:0]        irq_in,
    output logic [N_CFG*DATA_W-1:0] cfg_q,
    output logic [N_CMD*DATA_W-1:0] cmd_q,
    output logic [N_CMD-1:0]        cmd_start,
    output logic [DATA_W-1:0]       wbuf_q,
    output logic                    wbuf_load,
    output logic                    rbuf_pop,
    output logic                    core_rst
);

    logic  hw_rst;
    xfer_t wr_q;
    addr_t rd_addr_q;
    logic  wr_tog, rd_tog;
    logic  wr_pulse, wr_seen, rd_pulse, rd_seen;

    hif_reset_seq #(.CYCLES(SWRST_CYCLES)) u_rst (
        .clk(tck), .trst_n(trst_n), .hw_rst(hw_rst), .core_rst(core_rst)
    );

    hif_strobe_capture u_cap (
        .hw_rst(hw_rst), .wr_n(host_wr_n), .rd_n(host_rd_n),
        .addr(host_addr), .wdata(host_wdata),
        .wr_q(wr_q), .wr_tog(wr_tog), .rd_addr_q(rd_addr_q), .rd_tog(rd_tog)
    );

    hif_toggle_sync #(.STAGES(SYNC_STAGES)) u_wsync (
        .clk(tck), .rst(hw_rst), .tog(wr_tog), .pulse(wr_pulse), .seen(wr_seen)
    );

    hif_toggle_sync #(.STAGES(SYNC_STAGES)) u_rsync (
        .clk(tck), .rst(hw_rst), .tog(rd_tog), .pulse(rd_pulse), .seen(rd_seen)
    );

    hif_regfile u_regs (
        .clk(tck), .rst(core_rst),
        .wr_pulse(wr_pulse), .wr_q(wr_q),
        .rd_pulse(rd_pulse), .rd_addr_q(rd_addr_q),
        .host_addr(host_addr), .status_in(status_in), .rbuf_in(rbuf_in),
        .irq_in(irq_in),
        .cfg_q(cfg_q), .cmd_q(cmd_q), .cmd_start(cmd_start),
        .wbuf_q(wbuf_q), .wbuf_load(wbuf_load), .rbuf_pop(rbuf_pop),
        .rdata(host_rdata), .int_n(host_int_n)
    );

    // Busy while either toggle has not yet come back through its synchronizer.
    assign host_rdy_n = core_rst | (wr_tog ^ wr_seen) | (rd_tog ^ rd_seen);
    assign host_rd_oe = ~host_rd_n;

endmodule

// File: rtl/hif_checker.sv
module hif_checker
    import hostif_pkg::*;
(
    input logic             tck,
    input logic             trst_n,
    input logic             core_rst,
    input logic             host_rdy_n,
    input logic [N_CMD-1:0] cmd_start,
    input logic             rbuf_pop,
    input logic             wbuf_load
);

    a_r9_busy_in_reset: assert property (@(posedge tck) disable iff (!trst_n)
        core_rst |-> host_rdy_n);

    a_r9_quiet_in_reset: assert property (@(posedge tck) disable iff (!trst_n)
        core_rst |-> (cmd_start == '0 && !rbuf_pop && !wbuf_load));

    a_r4_one_command: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0(cmd_start));

    a_r4_command_single: assert property (@(posedge tck) disable iff (!trst_n)
        (cmd_start != '0) |=> (cmd_start == '0));

    a_r5_pop_single: assert property (@(posedge tck) disable iff (!trst_n)
        rbuf_pop |=> !rbuf_pop);

    a_r10_load_single: assert property (@(posedge tck) disable iff (!trst_n)
        wbuf_load |=> !wbuf_load);

endmodule

bind tbc_host_port hif_checker u_chk (
    .tck(tck), .trst_n(trst_n), .core_rst(core_rst), .host_rdy_n(host_rdy_n),
    .cmd_start(cmd_start), .rbuf_pop(rbuf_pop), .wbuf_load(wbuf_load)
);

// File: tb/tb_tbc_host_port.sv
module tb_tbc_host_port;

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic [4:0]    host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic          host_rd_n = 1'b1;
    logic          host_wr_n = 1'b1;
    logic [15:0]   host_rdata;
    logic          host_rd_oe, host_rdy_n, host_int_n;
    logic [15:0]   status_in = '0;
    logic [15:0]   rbuf_in = '0;
    logic [3:0]    irq_in = '0;
    logic [287:0]  cfg_q;
    logic [31:0]   cmd_q;
    logic [1:0]    cmd_start;
    logic [15:0]   wbuf_q;
    logic          wbuf_load, rbuf_pop, core_rst;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [15:0] cfg_m [18];
    logic [15:0] cmd_m [2];
    logic [15:0] wbuf_m;
    logic [3:0]  flags_m;

    always #2 tck = ~tck;

    tbc_host_port dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [4:0] a);
        if (a < 5'd18) return cfg_m[a];
        case (a)
            5'd18: return {12'h0, flags_m};
            5'd19: return status_in;
            5'd20: return cmd_m[0];
            5'd21: return cmd_m[1];
            5'd22: return rbuf_in;
            5'd23: return wbuf_m;
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_write(input logic [4:0] a, input logic [15:0] d);
        if (a < 5'd18) cfg_m[a] = d;
        else if (a == 5'd18) flags_m = flags_m & ~d[3:0];
        else if (a == 5'd20) cmd_m[0] = d;
        else if (a == 5'd21) cmd_m[1] = d;
        else if (a == 5'd23) wbuf_m = d;
    endtask

    task automatic model_clear();
        for (int i = 0; i < 18; i++) cfg_m[i] = '0;
        cmd_m[0] = '0; cmd_m[1] = '0; wbuf_m = '0; flags_m = '0;
    endtask

    task automatic wait_ready(output int cyc);
        cyc = 0;
        do begin
            @(negedge tck);
            cyc++;
        end while (host_rdy_n && cyc < 30);
    endtask

    // Returns at the negedge where ready has just returned low.
    task automatic host_write(input logic [4:0] a, input logic [15:0] d);
        int cyc;
        @(negedge tck);
        host_addr = a; host_wdata = d; host_wr_n = 1'b0;
        @(negedge tck);
        host_wr_n = 1'b1;
        #0.5;
        chk(host_rdy_n == 1'b1, "R3 ready high after write strobe", 64'(host_rdy_n), 64'd1);
        host_wdata = ~d;
        wait_ready(cyc);
        chk(cyc == 3, "R3 write recovery edges", 64'(cyc), 64'd3);
        chk(cmd_start == ((a == 5'd20) ? 2'b01 : (a == 5'd21) ? 2'b10 : 2'b00),
            "R4 R7 command pulse", 64'(cmd_start), 64'((a == 5'd20) ? 1 : (a == 5'd21) ? 2 : 0));
        chk(wbuf_load == (a == 5'd23), "R10 R7 load pulse", 64'(wbuf_load), 64'(a == 5'd23));
        chk(rbuf_pop == 1'b0, "R7 no pop on write", 64'(rbuf_pop), 64'd0);
        model_write(a, d);
    endtask

    task automatic host_read(input logic [4:0] a, input string req);
        int cyc;
        logic [15:0] got;
        @(negedge tck);
        host_addr = a; host_rd_n = 1'b0;
        #1;
        got = host_rdata;
        chk(host_rd_oe == 1'b1, "R6 output enable during read", 64'(host_rd_oe), 64'd1);
        chk(got == exp_read(a), req, 64'(got), 64'(exp_read(a)));
        @(negedge tck);
        host_rd_n = 1'b1;
        #0.5;
        chk(host_rd_oe == 1'b0, "R6 output enable after read", 64'(host_rd_oe), 64'd0);
        wait_ready(cyc);
        chk(cyc == 3, "R3 read recovery edges", 64'(cyc), 64'd3);
        chk(rbuf_pop == (a == 5'd22), "R5 pop pulse", 64'(rbuf_pop), 64'(a == 5'd22));
    endtask

    task automatic check_cfg_bus(input string req);
        for (int i = 0; i < 18; i++)
            chk(cfg_q[i*16 +: 16] == cfg_m[i], req, 64'(cfg_q[i*16 +: 16]), 64'(cfg_m[i]));
        chk(cmd_q == {cmd_m[1], cmd_m[0]}, "R4 command bus", 64'(cmd_q), 64'({cmd_m[1], cmd_m[0]}));
        chk(wbuf_q == wbuf_m, "R10 write buffer bus", 64'(wbuf_q), 64'(wbuf_m));
    endtask

    task automatic do_reset();
        int cyc;
        @(negedge tck);
        trst_n = 1'b0;
        repeat (4) @(negedge tck);
        chk(host_rdy_n && core_rst, "R9 busy during reset", 64'({host_rdy_n, core_rst}), 64'd3);
        chk(cfg_q == '0 && cmd_q == '0 && wbuf_q == '0, "R9 registers cleared", 64'(cfg_q[63:0]), 64'd0);
        chk(host_int_n == 1'b1, "R9 interrupt idle in reset", 64'(host_int_n), 64'd1);
        trst_n = 1'b1;
        wait_ready(cyc);
        chk(cyc == 8, "R9 software reset length", 64'(cyc), 64'd8);
        chk(core_rst == 1'b0, "R9 core reset released", 64'(core_rst), 64'd0);
        model_clear();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5A17);
        model_clear();
        do_reset();

        // R1 and R2: store, bus view, strobe-edge capture (data flipped after the edge)
        host_write(5'd5, 16'h1234);
        host_read(5'd5, "R2 R1 captured at strobe edge");
        host_write(5'd17, 16'hBEEF);
        host_write(5'd0, 16'h0000);
        check_cfg_bus("R1 configuration bus");

        // R4 commands, R10 write buffer
        host_write(5'd20, 16'hA5A5);
        host_write(5'd21, 16'h5A5A);
        host_write(5'd23, 16'hC3C3);
        host_read(5'd20, "R4 command readback");
        host_read(5'd21, "R4 command readback");
        host_read(5'd23, "R10 write buffer readback");

        // R5 and R6 read-only inputs
        rbuf_in = 16'h7E81; status_in = 16'h0F0F;
        host_read(5'd22, "R5 read buffer value");
        host_read(5'd19, "R6 status value");

        // R7 ignored addresses
        host_write(5'd19, 16'hFFFF);
        host_write(5'd22, 16'hFFFF);
        host_write(5'd24, 16'hFFFF);
        host_write(5'd31, 16'hFFFF);
        host_read(5'd27, "R7 unmapped reads zero");
        check_cfg_bus("R7 nothing changed");

        // R8 interrupts: mask bits 0 and 2
        host_write(5'd0, 16'h0005);
        @(negedge tck); irq_in = 4'b0010;
        @(negedge tck); irq_in = 4'b0000; flags_m = 4'b0010;
        chk(host_int_n == 1'b1, "R8 masked flag no interrupt", 64'(host_int_n), 64'd1);
        irq_in = 4'b0100;
        @(negedge tck); irq_in = 4'b0000; flags_m = 4'b0110;
        chk(host_int_n == 1'b0, "R8 enabled flag interrupts", 64'(host_int_n), 64'd0);
        host_read(5'd18, "R8 flag readback");
        host_write(5'd18, 16'h0004);
        chk(host_int_n == 1'b1, "R8 cleared interrupt", 64'(host_int_n), 64'd1);
        host_read(5'd18, "R8 flag after clear");
        // set wins over clear in the same cycle: apply edge is the third tck edge
        @(negedge tck);
        host_addr = 5'd18; host_wdata = 16'h0002; host_wr_n = 1'b0;
        @(negedge tck); host_wr_n = 1'b1;
        @(negedge tck); @(negedge tck); irq_in = 4'b0010;
        @(negedge tck); irq_in = 4'b0000;
        chk(host_rdy_n == 1'b0, "R3 ready after clear write", 64'(host_rdy_n), 64'd0);
        host_read(5'd18, "R8 set wins over clear");

        // Constrained random traffic, irq quiet
        for (int n = 0; n < 60; n++) begin
            logic [4:0] a;
            logic [15:0] d;
            a = 5'($urandom_range(0, 31));
            d = 16'($urandom);
            if (a == 5'd0) d[3:0] = 4'h0;
            status_in = 16'($urandom);
            rbuf_in = 16'($urandom);
            if ($urandom_range(0, 1) == 1) host_write(a, d);
            else host_read(a, "R1 R5 R6 R7 random read");
        end
        check_cfg_bus("R1 random bus");

        do_reset();
        host_read(5'd17, "R9 cleared after reset");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule